// File: doc/BRIEF.md
# ISA System Clock Generator with Address-Latch Alignment

This block derives the ISA system clock from the host clock by integer division. The ratio comes from a frequency select input, so that the result lands near 8 MHz for each supported host frequency. It also drives the address-latch-enable strobe (`bale`) for host-initiated ISA cycles.

The system clock is not a plain free-running divider. When a host cycle asks to start, the divider is restarted with a fresh low phase. The strobe goes high on the next system-clock rising edge and stays high for one whole system-clock period. It then falls on the following rising edge, and a one-clock `cyc_start` pulse marks that moment as the launch of the ISA cycle. If the cycle is aborted while the strobe is high, the strobe stays high and no pulse is given. The strobe is lowered only by the next cycle that runs to completion.

Top module: `isa_sysclk_gen`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `sysclk`, `bale` and `cyc_start` are all 0.
- R2: `freq_sel` selects the divide ratio N as follows: 0 gives 4 (33.33 MHz host), 1 gives 3, 2 gives 4, 3 gives 5 and 4 gives 6 (24/32/40/48 MHz host), and 5 to 7 give 4. The ratio is sampled only at the start of a system-clock period: at the wrap of the counter, or when a start restarts the divider.
- R3: With no cycle in progress, `sysclk` repeats a low phase of ceil(N/2) host clocks followed by a high phase of floor(N/2) host clocks.
- R4: A `start_req` sampled while idle, or while the strobe is held after an abort, restarts the divider. `sysclk` is 0 on the next clock and stays low for ceil(N/2) clocks. `bale` is 1 from the clock on which `sysclk` next rises.
- R5: Once `bale` has risen, it stays 1 for N host clocks (one system-clock period). It falls on the same clock on which `sysclk` rises.
- R6: `cyc_start` is 1 for exactly one host clock, on the clock in which `bale` falls, and at no other time.
- R7: `abort_req` sampled while `bale` is high and waiting to fall (including the fall clock itself) keeps `bale` at 1. It suppresses `cyc_start`, and `sysclk` keeps running unstretched.
- R8: After an abort, the next accepted `start_req` restarts the divider as in R4 while `bale` remains 1. `bale` then falls, with `cyc_start`, on the second `sysclk` rising edge after the restart.
- R9: `start_req` has no effect while a cycle is being aligned or while `bale` is waiting to fall.
- R10: `abort_req` has no effect while idle or while a cycle is still being aligned (before `bale` rises).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| freq_sel | input | 3 | Host frequency select (encoding in R2) |
| start_req | input | 1 | Request to launch a host-initiated ISA cycle |
| abort_req | input | 1 | Abort of the cycle whose strobe is high |
| sysclk | output | 1 | Divided ISA system clock |
| bale | output | 1 | Address-latch-enable strobe |
| cyc_start | output | 1 | One-clock pulse when `bale` falls and the cycle launches |

## Verification
The bench issues a start at every phase of the running divider and for every divide ratio. A design that waited for the next natural edge instead of restarting would show a short or misplaced first low phase. A ratio change is made in the middle of a period, so a design that loaded the ratio at once would shorten or lengthen that period, or push the counter out of range. Aborts are placed in idle, during alignment, mid-period and on the exact fall clock. A design that dropped the strobe, emitted a pulse after an abort, or acted on an abort before the strobe rose would disagree with the model. Repeated starts during a cycle, and the start that follows an abort, check that a busy request is ignored and that the held strobe survives the restart.

// File: rtl/isa_clk_pkg.sv
package isa_clk_pkg;

  localparam int DIV_W = 3;
  localparam int SEL_W = 3;

  typedef logic [DIV_W-1:0] div_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ACTIVE,
    ST_HELD
  } bale_st_e;

  // Divide ratio for a frequency select code.
  function automatic div_t ratio_of(input logic [SEL_W-1:0] sel);
    div_t r;
    if (sel == '0) begin
      r = div_t'(4);
    end else if (sel <= SEL_W'(4)) begin
      r = div_t'(sel + SEL_W'(2));
    end else begin
      r = div_t'(4);
    end
    return r;
  endfunction

  // Length of the low phase: ceil(n/2).
  function automatic div_t low_len(input div_t n);
    logic [DIV_W:0] s;
    s = {1'b0, n} + {{DIV_W{1'b0}}, 1'b1};
    return s[DIV_W:1];
  endfunction

endpackage

// File: rtl/isa_ratio_latch.sv
module isa_ratio_latch
  import isa_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output div_t             div_o
);

  div_t div_q;
  div_t div_d;

  always_comb begin
    div_d = div_q;
    if (load_i) begin
      div_d = ratio_of(sel_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= div_t'(4);
    end else begin
      div_q <= div_d;
    end
  end

  assign div_o = div_q;

  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q >= div_t'(3)) && (div_q <= div_t'(6))) else $error("ratio out of range"); // R2

  AST_RATIO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(div_q)) else $error("ratio changed mid-period"); // R2

endmodule

// File: rtl/isa_clk_divider.sv
module isa_clk_divider
  import isa_clk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic realign_i,
  input  div_t div_i,
  output logic sysclk_o,
  output logic rise_o,
  output logic restart_o
);

  div_t cnt_q;
  div_t cnt_d;
  div_t cnt_inc;
  div_t lo_len;
  logic sysclk_q;
  logic sysclk_d;
  logic wrap;
  logic restart;

  assign lo_len  = low_len(div_i);
  assign cnt_inc = cnt_q + div_t'(1);
  assign wrap    = (cnt_q == (div_i - div_t'(1)));
  assign restart = realign_i | wrap;

  always_comb begin
    if (restart) begin
      cnt_d    = '0;
      sysclk_d = 1'b0;
    end else begin
      cnt_d    = cnt_inc;
      sysclk_d = (cnt_inc >= lo_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sysclk_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      sysclk_q <= sysclk_d;
    end
  end

  assign sysclk_o  = sysclk_q;
  assign rise_o    = !restart && (cnt_inc == lo_len);
  assign restart_o = restart;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_i) else $error("counter beyond ratio"); // R2

  AST_REALIGN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    realign_i |=> !sysclk_q) else $error("realign did not force low"); // R4

  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> $rose(sysclk_q)) else $error("predicted rise missing"); // R3

endmodule

// File: rtl/isa_bale_fsm.sv
module isa_bale_fsm
  import isa_clk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  input  logic rise_i,
  output logic realign_o,
  output logic bale_o,
  output logic cyc_start_o
);

  bale_st_e st_q;
  bale_st_e st_d;
  logic     bale_q;
  logic     bale_d;
  logic     pulse_q;
  logic     pulse_d;
  logic     realign;

  always_comb begin
    st_d    = st_q;
    bale_d  = bale_q;
    pulse_d = 1'b0;
    realign = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_HELD: begin
        if (start_i) begin
          realign = 1'b1;
          st_d    = ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        if (rise_i) begin
          bale_d = 1'b1;
          st_d   = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (abort_i) begin
          st_d = ST_HELD;
        end else if (rise_i) begin
          bale_d  = 1'b0;
          pulse_d = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bale_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      bale_q  <= bale_d;
      pulse_q <= pulse_d;
    end
  end

  assign realign_o   = realign;
  assign bale_o      = bale_q;
  assign cyc_start_o = pulse_q;

  AST_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HELD) |-> bale_q) else $error("held strobe dropped"); // R7

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q) else $error("pulse longer than one clock"); // R6

  AST_PULSE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (!bale_q && $past(bale_q))) else $error("pulse not on fall"); // R6

  AST_BUSY_NO_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ALIGN) || (st_q == ST_ACTIVE)) |-> !realign) else $error("busy restart"); // R9

endmodule

// File: rtl/isa_sysclk_gen.sv
module isa_sysclk_gen
  import isa_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] freq_sel,
  input  logic             start_req,
  input  logic             abort_req,
  output logic             sysclk,
  output logic             bale,
  output logic             cyc_start
);

  div_t div_cur;
  logic restart;
  logic realign;
  logic rise;

  isa_ratio_latch u_ratio (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (restart),
    .sel_i  (freq_sel),
    .div_o  (div_cur)
  );

  isa_clk_divider u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .realign_i (realign),
    .div_i     (div_cur),
    .sysclk_o  (sysclk),
    .rise_o    (rise),
    .restart_o (restart)
  );

  isa_bale_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_req),
    .abort_i     (abort_req),
    .rise_i      (rise),
    .realign_o   (realign),
    .bale_o      (bale),
    .cyc_start_o (cyc_start)
  );

  AST_FALL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bale) |-> $rose(sysclk)) else $error("strobe fell off edge"); // R5

  AST_UP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bale) |-> $rose(sysclk)) else $error("strobe rose off edge"); // R4

  AST_PULSE_IFF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bale) |-> cyc_start) else $error("fall without pulse"); // R6

endmodule

// File: tb/isa_sysclk_gen_test.sv
module isa_sysclk_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] freq_sel;
  logic       start_req;
  logic       abort_req;
  logic       sysclk;
  logic       bale;
  logic       cyc_start;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Reference model state
  int m_cnt, m_div, m_st, m_bale, m_pulse, m_sys;

  isa_sysclk_gen uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_sel  (freq_sel),
    .start_req (start_req),
    .abort_req (abort_req),
    .sysclk    (sysclk),
    .bale      (bale),
    .cyc_start (cyc_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int ratio(input int s);
    if (s == 0) return 4;
    if (s <= 4) return s + 2;
    return 4;
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got=%0d expected=%0d at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "sysclk", int'(sysclk), m_sys);
    check(tag, "bale", int'(bale), m_bale);
    check(tag, "cyc_start", int'(cyc_start), m_pulse);
  endtask

  // states: 0 idle, 1 aligning, 2 strobe high, 3 held after abort
  task automatic step(input bit s, input bit a, input int sel_v, input string tag);
    int lo;
    bit realign, wrap, restart, rise;
    start_req = s;
    abort_req = a;
    freq_sel  = sel_v[2:0];
    lo      = (m_div + 1) / 2;
    realign = s && (m_st == 0 || m_st == 3);
    wrap    = (m_cnt == m_div - 1);
    restart = realign || wrap;
    rise    = !restart && (m_cnt + 1 == lo);
    m_sys   = (!restart && (m_cnt + 1 >= lo)) ? 1 : 0;
    m_pulse = 0;
    case (m_st)
      0, 3: if (s) m_st = 1;
      1: if (rise) begin m_bale = 1; m_st = 2; end
      2: begin
        if (a) m_st = 3;
        else if (rise) begin m_bale = 0; m_pulse = 1; m_st = 0; end
      end
      default: m_st = 0;
    endcase
    if (restart) begin
      m_cnt = 0;
      m_div = ratio(sel_v);
    end else begin
      m_cnt = m_cnt + 1;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    start_req = 1'b0;
    abort_req = 1'b0;
    freq_sel = 3'd0;
    m_cnt = 0; m_div = 4; m_st = 0; m_bale = 0; m_pulse = 0; m_sys = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step(0, 0, 0, "R1");

    // unstretched waveform at the default ratio
    repeat (12) step(0, 0, 0, "R3");

    // every select code, changed mid-period
    for (int sel = 1; sel < 8; sel++) begin
      step(0, 0, 0, "R2");
      repeat (15) step(0, 0, sel, "R2");
    end

    // a start from idle, then the full strobe period and the pulse
    step(1, 0, 2, "R4");
    repeat (14) step(0, 0, 2, "R5");

    // starts at every phase of a ratio-5 divider
    repeat (10) step(0, 0, 3, "R3");
    for (int ph = 0; ph < 5; ph++) begin
      repeat (ph) step(0, 0, 3, "R4");
      step(1, 0, 3, "R4");
      repeat (14) step(0, 0, 3, "R6");
    end

    // starts while busy are ignored (ratio 6)
    repeat (8) step(0, 0, 4, "R9");
    step(1, 0, 4, "R9");
    repeat (9) step(1, 0, 4, "R9");
    repeat (12) step(0, 0, 4, "R9");

    // aborts while idle and while aligning have no effect
    repeat (6) step(0, 1, 0, "R10");
    step(1, 0, 0, "R10");
    step(0, 1, 0, "R10");
    repeat (10) step(0, 0, 0, "R10");

    // abort mid-period, free run, then the next start completes
    step(1, 0, 1, "R7");
    repeat (3) step(0, 0, 1, "R7");
    step(0, 1, 1, "R7");
    repeat (10) step(0, 0, 1, "R7");
    step(1, 0, 1, "R8");
    repeat (10) step(0, 0, 1, "R8");

    // abort on the exact fall clock (ratio 4: fall 6 clocks after start)
    step(1, 0, 2, "R7");
    repeat (5) step(0, 0, 2, "R7");
    step(0, 1, 2, "R7");
    repeat (8) step(0, 0, 2, "R7");
    step(1, 0, 5, "R8");
    repeat (12) step(0, 0, 5, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule